// File: doc/BRIEF.md
# Flash NVRAM Image Integrity Checker

This block judges whether a bank image of non-volatile settings, read out of flash one byte per clock, is intact. The image arrives as a byte stream with a valid qualifier, a strobe that marks the first byte and a strobe that marks the final byte. While the bytes pass, the block keeps three things. It keeps a short header sum. It keeps a pair of modulo-65521 accumulators over the body. It also captures the stored reference fields from the header.

Two cycles after the final byte is accepted, the block raises a one-cycle done pulse with its verdict. The verdict carries a pass flag, one flag per failure reason, and the 32-bit generation number of the image. The generation number is forced to zero unless the image passes. A controller that holds two banks can stream each bank through the checker and keep the bank with the higher reported generation.

Top module: `nvc_image_check`

## Requirements
- R1: While reset is high and on the first cycle after it, done_o, ok_o, bad_sig_o, bad_hdr_o, bad_sum_o and gen_o are all zero.
- R2: The byte at offset 0 (the one taken with in_start) must equal 0x5A. Any other value sets bad_sig_o in the verdict.
- R3: The byte at offset 1 is the stored header sum. The reference is formed as follows. A 16-bit sum is taken of the offset-0 byte and the bytes at offsets 2 through 15. Bits 15:8 are then added into bits 7:0 repeatedly until the value fits in 8 bits. A mismatch with the stored byte sets bad_hdr_o.
- R4: The long sum runs over every byte from offset 20 up to and including the last byte. Accumulator A starts at 1 and accumulator B starts at 0. For each byte, A becomes (A + byte) mod 65521, and then B becomes (B + A) mod 65521. The word {B, A}, with B in bits 31:16, must equal the big-endian word at offsets 16 to 19 (offset 16 is the most significant byte). A mismatch sets bad_sum_o. Both accumulators always stay below 65521.
- R5: The verdict is ok_o = 1 only when none of the three failure flags is set. In that case gen_o carries the big-endian word at offsets 20 to 23. Otherwise gen_o is 0.
- R6: done_o is high for exactly one cycle. It appears two rising edges after the edge that accepts the byte carrying in_last, and exactly one verdict appears per such byte.
- R7: A byte accepted with in_start restarts the image at offset 0 and clears every accumulator. This holds even if a previous image was cut short. It also holds in the cycle right after a final byte, while that earlier image is still being judged.
- R8: In a cycle where in_valid is low, in_data, in_start and in_last are ignored. The offset and the accumulators hold their values.
- R9: The failure flags are independent, and several can be set in one verdict. A wrong signature byte also changes the header reference, so it raises both bad_sig_o and bad_hdr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on in_data this cycle |
| in_start | input | 1 | The present byte is offset 0 of a new image |
| in_last | input | 1 | The present byte is the final byte of the image |
| in_data | input | 8 | Image byte |
| done_o | output | 1 | One-cycle pulse marking the verdict outputs as valid |
| ok_o | output | 1 | Image passed every check |
| bad_sig_o | output | 1 | Signature byte mismatch |
| bad_hdr_o | output | 1 | Header sum mismatch |
| bad_sum_o | output | 1 | Long sum mismatch |
| gen_o | output | 32 | Generation number of a passing image, else zero |

## Verification
The judging of one image and the restart for the next can fall in the same cycle. This happens when the first byte of a new image arrives right after the final byte of the previous one. The verdict is then formed from the accumulator registers in the same cycle that in_start clears them.

The bench provokes this overlap by streaming several images back to back with no idle cycle between them. Each verdict is recorded by a monitor and compared, in order, with expectations computed independently for each image. A wrong value or a missing pulse in this run shows that the clear disturbed the pending judgment.

// File: rtl/nvc_pkg.sv
package nvc_pkg;
  localparam logic [7:0]  SIG_BYTE   = 8'h5A;
  localparam int unsigned MOD_BASE   = 65521;
  localparam int unsigned HDR_SUM_HI = 15;
  localparam int unsigned REF_OFS    = 16;
  localparam int unsigned GEN_OFS    = 20;
  localparam int unsigned BODY_OFS   = 20;

  // carry-fold of a 16-bit sum into 8 bits; three folds cover any input
  function automatic logic [7:0] fold8(input logic [15:0] s);
    logic [15:0] t;
    t = s;
    for (int k = 0; k < 3; k++) t = {8'h00, t[7:0]} + {8'h00, t[15:8]};
    return t[7:0];
  endfunction
endpackage

// File: rtl/nvc_hdr_sum.sv
module nvc_hdr_sum
  import nvc_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic             start_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic             sig_ok_o,
  output logic             hdr_ok_o
);
  logic [15:0] sum_q;
  logic [7:0]  sig_q, ck_q;
  logic [15:0] sum_base;
  logic        in_hdr;

  assign sum_base = start_i ? 16'h0000 : sum_q;
  assign in_hdr   = (idx_i == IDX_W'(0)) ||
                    ((idx_i >= IDX_W'(2)) && (idx_i <= IDX_W'(HDR_SUM_HI)));

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      sig_q <= '0;
      ck_q  <= '0;
    end else if (take_i) begin
      sum_q <= in_hdr ? sum_base + {8'h00, data_i} : sum_base;
      if (idx_i == IDX_W'(0)) sig_q <= data_i;
      if (idx_i == IDX_W'(1)) ck_q  <= data_i;
    end
  end

  assign sig_ok_o = (sig_q == SIG_BYTE);
  assign hdr_ok_o = (fold8(sum_q) == ck_q);

  // R3
  hdr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sum_q < 16'h1000);
endmodule

// File: rtl/nvc_mod_sum.sv
module nvc_mod_sum
  import nvc_pkg::*;
#(
  parameter int unsigned MOD = MOD_BASE
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        take_i,
  input  logic        start_i,
  input  logic        body_i,
  input  logic [7:0]  data_i,
  output logic [15:0] lo_o,
  output logic [15:0] hi_o
);
  localparam logic [16:0] MODV = 17'(MOD);

  logic [15:0] lo_q, hi_q, lo_b, hi_b;
  logic [16:0] lo_add, hi_add;
  logic [15:0] lo_n, hi_n;

  assign lo_b   = start_i ? 16'd1 : lo_q;
  assign hi_b   = start_i ? 16'd0 : hi_q;
  assign lo_add = {1'b0, lo_b} + {9'h000, data_i};
  assign lo_n   = (lo_add >= MODV) ? 16'(lo_add - MODV) : lo_add[15:0];
  assign hi_add = {1'b0, hi_b} + {1'b0, lo_n};
  assign hi_n   = (hi_add >= MODV) ? 16'(hi_add - MODV) : hi_add[15:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= 16'd1;
      hi_q <= 16'd0;
    end else if (take_i) begin
      lo_q <= body_i ? lo_n : lo_b;
      hi_q <= body_i ? hi_n : hi_b;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R4
  acc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (17'(lo_q) < MODV) && (17'(hi_q) < MODV));
  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    take_i && start_i && !body_i |=> (lo_q == 16'd1) && (hi_q == 16'd0));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> $stable(lo_q) && $stable(hi_q));
endmodule

// File: rtl/nvc_word_cap.sv
module nvc_word_cap #(
  parameter int IDX_W = 14,
  parameter int BASE  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic [31:0]      word_o
);
  logic [31:0] word_q;
  logic        hit;

  assign hit = take_i && (idx_i >= IDX_W'(BASE)) && (idx_i < IDX_W'(BASE + 4));

  // big-endian: lowest offset lands in the top byte
  for (genvar b = 0; b < 4; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) word_q[8*(3-b) +: 8] <= '0;
      else if (take_i && (idx_i == IDX_W'(BASE + b))) word_q[8*(3-b) +: 8] <= data_i;
    end
  end

  assign word_o = word_q;

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(word_q));
endmodule

// File: rtl/nvc_image_check.sv
module nvc_image_check
  import nvc_pkg::*;
#(
  parameter int IMG_BYTES = 8192
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_start,
  input  logic        in_last,
  input  logic [7:0]  in_data,
  output logic        done_o,
  output logic        ok_o,
  output logic        bad_sig_o,
  output logic        bad_hdr_o,
  output logic        bad_sum_o,
  output logic [31:0] gen_o
);
  localparam int IDX_W = $clog2(IMG_BYTES) + 1;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q, cur_idx;
  logic             take, start, body, eval_q;
  logic             sig_ok, hdr_ok, sum_ok;
  logic [15:0]      lo, hi;
  logic [31:0]      ref_word, gen_word;
  logic             done_q, ok_q, bsig_q, bhdr_q, bsum_q;
  logic [31:0]      gen_q;

  assign take    = in_valid;
  assign start   = in_valid && in_start;
  assign cur_idx = start ? '0 : idx_q;
  assign body    = (cur_idx >= IDX_W'(BODY_OFS));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      eval_q <= 1'b0;
    end else begin
      if (take) idx_q <= (cur_idx == IDX_MAX) ? cur_idx : cur_idx + 1'b1;
      eval_q <= take && in_last;
    end
  end

  nvc_hdr_sum #(.IDX_W(IDX_W)) hdr_i (
    .clk(clk), .rst(rst), .take_i(take), .start_i(start),
    .idx_i(cur_idx), .data_i(in_data), .sig_ok_o(sig_ok), .hdr_ok_o(hdr_ok));

  nvc_mod_sum #(.MOD(MOD_BASE)) long_i (
    .clk(clk), .rst(rst), .take_i(take), .start_i(start), .body_i(body),
    .data_i(in_data), .lo_o(lo), .hi_o(hi));

  nvc_word_cap #(.IDX_W(IDX_W), .BASE(REF_OFS)) ref_i (
    .clk(clk), .rst(rst), .take_i(take), .idx_i(cur_idx), .data_i(in_data),
    .word_o(ref_word));

  nvc_word_cap #(.IDX_W(IDX_W), .BASE(GEN_OFS)) gen_i (
    .clk(clk), .rst(rst), .take_i(take), .idx_i(cur_idx), .data_i(in_data),
    .word_o(gen_word));

  assign sum_ok = ({hi, lo} == ref_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      bsig_q <= 1'b0;
      bhdr_q <= 1'b0;
      bsum_q <= 1'b0;
      gen_q  <= '0;
    end else begin
      done_q <= eval_q;
      if (eval_q) begin
        bsig_q <= !sig_ok;
        bhdr_q <= !hdr_ok;
        bsum_q <= !sum_ok;
        ok_q   <= sig_ok && hdr_ok && sum_ok;
        gen_q  <= (sig_ok && hdr_ok && sum_ok) ? gen_word : 32'h0;
      end
    end
  end

  assign done_o    = done_q;
  assign ok_o      = ok_q;
  assign bad_sig_o = bsig_q;
  assign bad_hdr_o = bhdr_q;
  assign bad_sum_o = bsum_q;
  assign gen_o     = gen_q;

  // R6
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    eval_q |=> done_q);
  // R6
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(eval_q));
  // R5
  gen_zero_chk: assert property (@(posedge clk) disable iff (rst)
    done_q && !ok_q |-> gen_q == 32'h0);
  // R9
  ok_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done_q && ok_q |-> !(bsig_q || bhdr_q || bsum_q));
endmodule

// File: tb/nvc_image_check_tb.sv
`timescale 1ns/1ps
module nvc_image_check_tb_top;
  localparam int N = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic done_o, ok_o, bad_sig_o, bad_hdr_o, bad_sum_o;
  logic [31:0] gen_o;

  always #2 clk = ~clk;

  nvc_image_check #(.IMG_BYTES(N)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_data(in_data), .done_o(done_o), .ok_o(ok_o),
    .bad_sig_o(bad_sig_o), .bad_hdr_o(bad_hdr_o), .bad_sum_o(bad_sum_o),
    .gen_o(gen_o));

  int checks = 0, fails = 0;

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // vector: [39:37] seed, [36] back-to-back with next, [35] gaps, [34:32] mode, [31:0] generation
  // modes: 0 clean, 1 signature 0x5B, 2 header byte +1, 3 stored long sum bit flip, 4 final body byte flip
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {3'd1, 1'b0, 1'b0, 3'd0, 32'h0000_0001},
    {3'd2, 1'b0, 1'b1, 3'd0, 32'hDEAD_BEEF},
    {3'd3, 1'b0, 1'b0, 3'd1, 32'h1234_5678},
    {3'd4, 1'b0, 1'b0, 3'd2, 32'h0000_0007},
    {3'd5, 1'b1, 1'b0, 3'd3, 32'h0000_0009},
    {3'd6, 1'b1, 1'b1, 3'd4, 32'h00A0_B0C0},
    {3'd7, 1'b0, 1'b0, 3'd0, 32'hFFFF_FFFF}
  };

  int          cur_seed, cur_mode;
  logic [31:0] cur_gen, cur_adl;
  logic [7:0]  cur_hdr;

  function automatic logic [7:0] raw(input int i);
    if (i == 0) return 8'h5A;
    if (i == 2) return 8'h1F;
    if (i == 3) return 8'hEC;
    if (i >= 4 && i <= 15) return 8'(8'h41 + i + cur_seed);
    if (i >= 20 && i <= 23) return cur_gen[8*(23-i) +: 8];
    return 8'(i * 13 + cur_seed * 29 + i / 256);
  endfunction

  function automatic logic [7:0] fin(input int i);
    logic [7:0] b;
    if (i == 1) b = cur_hdr + ((cur_mode == 2) ? 8'd1 : 8'd0);
    else if (i >= 16 && i <= 19) b = cur_adl[8*(19-i) +: 8];
    else b = raw(i);
    if (i == 0 && cur_mode == 1) b = 8'h5B;
    if (i == 19 && cur_mode == 3) b = b ^ 8'h01;
    if (i == N - 1 && cur_mode == 4) b = b ^ 8'h80;
    return b;
  endfunction

  task automatic prep(input int seed, input int mode, input logic [31:0] gen);
    int s, a, bsum;
    cur_seed = seed; cur_mode = mode; cur_gen = gen;
    s = 32'h5A;
    for (int i = 2; i <= 15; i++) s += raw(i);
    while (s > 255) s = (s & 255) + (s >> 8);
    cur_hdr = 8'(s);
    a = 1; bsum = 0;
    for (int i = 20; i < N; i++) begin
      a = (a + raw(i)) % 65521;
      bsum = (bsum + a) % 65521;
    end
    cur_adl = {16'(bsum), 16'(a)};
  endtask

  logic        e_ok [16];
  logic [2:0]  e_fl [16];
  logic [31:0] e_gen [16];
  int          e_n = 0;
  logic        g_ok [16];
  logic [2:0]  g_fl [16];
  logic [31:0] g_gen [16];
  int          g_n = 0;

  task automatic expect_v(input int mode, input logic [31:0] gen);
    logic [2:0] fl;
    fl = (mode == 1) ? 3'b110 : (mode == 2) ? 3'b010 : (mode >= 3) ? 3'b001 : 3'b000;
    e_fl[e_n] = fl;
    e_ok[e_n] = (fl == 3'b000);
    e_gen[e_n] = (fl == 3'b000) ? gen : 32'h0;
    e_n++;
  endtask

  // drives len bytes; last is marked only when the full image is sent
  task automatic stream(input bit gaps, input int len);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 5 == 3)) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b1; in_last = 1'b1; in_data = 8'hA5; // R8
      end
      @(negedge clk);
      in_valid = 1'b1; in_start = (i == 0); in_last = (i == N - 1); in_data = fin(i);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_data = 8'h00;
    repeat (n) @(negedge clk);
  endtask

  int  edge_cnt = 0, last_edge = -10;
  bit  prev_done = 1'b0;
  always @(posedge clk) begin
    if (in_valid && in_last) last_edge = edge_cnt;
    edge_cnt++;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        chk(!prev_done, "R6 pulse width", 32'(prev_done), 32'h0);
        chk(edge_cnt - last_edge == 2, "R6 latency", 32'(edge_cnt - last_edge), 32'd2);
        if (g_n < 16) begin
          g_ok[g_n] = ok_o;
          g_fl[g_n] = {bad_sig_o, bad_hdr_o, bad_sum_o};
          g_gen[g_n] = gen_o;
        end
        g_n++;
      end
      prev_done = done_o;
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({done_o, ok_o, bad_sig_o, bad_hdr_o, bad_sum_o} == 5'b0, "R1 flags in reset",
        32'({done_o, ok_o, bad_sig_o, bad_hdr_o, bad_sum_o}), 32'h0);
    chk(gen_o == 32'h0, "R1 gen in reset", gen_o, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk({done_o, ok_o, bad_sig_o, bad_hdr_o, bad_sum_o} == 5'b0, "R1 flags after reset",
        32'({done_o, ok_o, bad_sig_o, bad_hdr_o, bad_sum_o}), 32'h0);

    // table walk: R2 R3 R4 R5 R9; entries 4..6 run back to back for R7
    for (int v = 0; v < NV; v++) begin
      prep(int'(VEC[v][39:37]), int'(VEC[v][34:32]), VEC[v][31:0]);
      expect_v(int'(VEC[v][34:32]), VEC[v][31:0]);
      stream(VEC[v][35], N);
      if (!VEC[v][36]) idle(4);
    end

    // R7: a cut-short bad image followed at once by a clean one
    prep(2, 1, 32'h0000_0033);
    stream(1'b0, 300);
    prep(3, 0, 32'h5555_AAAA);
    expect_v(0, 32'h5555_AAAA);
    stream(1'b0, N);
    idle(4);

    // R1: reset in the middle of an image, then a clean image
    prep(5, 0, 32'h0000_0100);
    stream(1'b0, 500);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk({done_o, ok_o, gen_o} == 34'h0, "R1 mid-stream reset", gen_o, 32'h0);
    rst = 1'b0;
    prep(6, 0, 32'h0000_0101);
    expect_v(0, 32'h0000_0101);
    stream(1'b0, N);
    idle(6);

    chk(g_n == e_n, "R6 verdict count", 32'(g_n), 32'(e_n));
    for (int k = 0; k < e_n && k < g_n; k++) begin
      chk(g_ok[k] == e_ok[k], "R5 ok", 32'(g_ok[k]), 32'(e_ok[k]));
      chk(g_fl[k] == e_fl[k], "R9 flags R2 R3 R4", 32'(g_fl[k]), 32'(e_fl[k]));
      chk(g_gen[k] == e_gen[k], "R5 generation", g_gen[k], e_gen[k]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule